// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative store of page translations. Each slot holds a virtual page number tag, a physical page number, an 8-bit address-space number, a global flag, a valid flag, per-mode read and write permission masks, and two fault-on-access flags (one for reads, one for writes). A lookup port compares a virtual address and an address-space number against every slot at once. In the same cycle it returns a hit flag, the index of the matching slot and that slot's contents.

New translations are written at a single round-robin replacement pointer. The slot at that pointer can also be read back directly, and the pointer can be stepped on request. Three invalidation operations are available:
- clear everything;
- clear every non-global slot, which is a process switch;
- clear one page within one address space.

The page size is 8 KB, so the page number is the virtual address above bit 12. An instruction-side instance would use 48 slots and a data-side instance 64 slots.

Top module: `asn_tlb`

## Requirements
- R1: The lookup reports a hit only for a slot that is valid, whose tag equals lk_vaddr[VA_W-1:13], and which is either global or stores an address-space number equal to lk_asn. The lookup outputs are combinational from the stored contents.
- R2: When several slots hit, the lowest-indexed slot wins, and lk_idx gives that index.
- R3: flush_all clears every valid flag and returns the replacement pointer to 0. It dominates every other request in the same cycle, and any insert requested with it is dropped.
- R4: flush_proc invalidates every slot whose global flag is clear and leaves global slots valid.
- R5: flush_page invalidates each valid slot whose tag equals flush_vaddr[VA_W-1:13] and which is either global or carries flush_asn. Other slots are untouched.
- R6: ins_en writes the slot at the replacement pointer, overwriting any valid occupant, sets the tag from the page number of ins_vaddr, sets the valid flag, and advances the pointer. The pointer wraps from ENTRIES-1 to 0.
- R7: The readback outputs show the slot at the replacement pointer. rp_adv advances the pointer by one. ins_en together with rp_adv advances it by one only.
- R8: A lookup in the same cycle as an insert sees the contents from before the insert. flush_proc or flush_page in the same cycle as an insert act on the old contents, and the newly inserted slot stays valid.
- R9: After reset, no slot is valid, the pointer is 0 and the lookup misses.
- R10: On a hit, lk_ppn, lk_global, lk_rd_en, lk_wr_en, lk_fault_rd and lk_fault_wr give the hitting slot's fields. On a miss they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hitting slot |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_global | output | 1 | Global flag of the hit |
| lk_rd_en | output | MODES | Read enable per mode of the hit |
| lk_wr_en | output | MODES | Write enable per mode of the hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| ins_en | input | 1 | Insert request |
| ins_vaddr | input | VA_W | Virtual address of the new slot |
| ins_ppn | input | PPN_W | Physical page of the new slot |
| ins_asn | input | ASN_W | Address-space number of the new slot |
| ins_global | input | 1 | Global flag of the new slot |
| ins_rd_en | input | MODES | Read enables of the new slot |
| ins_wr_en | input | MODES | Write enables of the new slot |
| ins_fault_rd | input | 1 | Fault-on-read of the new slot |
| ins_fault_wr | input | 1 | Fault-on-write of the new slot |
| flush_all | input | 1 | Invalidate all slots, pointer to 0 |
| flush_proc | input | 1 | Invalidate non-global slots |
| flush_page | input | 1 | Invalidate one page in one address space |
| flush_vaddr | input | VA_W | Page address for flush_page |
| flush_asn | input | ASN_W | Address-space number for flush_page |
| rp_adv | input | 1 | Advance the replacement pointer |
| rp_ptr | output | IDX_W | Replacement pointer |
| rp_valid | output | 1 | Valid flag of the slot at the pointer |
| rp_vpn | output | VA_W-13 | Tag of the slot at the pointer |
| rp_ppn | output | PPN_W | Physical page of the slot at the pointer |
| rp_asn | output | ASN_W | Address-space number of the slot at the pointer |
| rp_global | output | 1 | Global flag of the slot at the pointer |

## Verification
The bench builds the block with ENTRIES = 4 and keeps the default address, page and address-space widths. With four slots, a few inserts bring the pointer to its wrap from 3 to 0 and force an insert to overwrite a valid occupant. The small size also lets one page sit in two slots at once, one private and one global, which exercises the lowest-index rule. Same-cycle combinations are driven at this size as well: insert with lookup, insert with flush_proc, insert with rp_adv, and flush_all with a pending insert.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
  // Number of privilege modes covered by the permission masks.
  localparam int MODES = 4;
  // log2 of the page size in bytes (8 KB pages).
  localparam int PAGE_SHIFT = 13;
endpackage

// File: rtl/asn_tlb_match.sv
// Parallel tag/address-space comparison across all slots.
module asn_tlb_match #(
  parameter int N     = 48,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     glob,
  input  logic [VPN_W-1:0] tag   [N],
  input  logic [ASN_W-1:0] asn   [N],
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [ASN_W-1:0] req_asn,
  output logic [N-1:0]     match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && (tag[i] == req_vpn) &&
                      (glob[i] || (asn[i] == req_asn));
  end
endmodule

// File: rtl/asn_tlb_prienc.sv
// Lowest-index-first priority encoder.
module asn_tlb_prienc #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/asn_tlb_rr.sv
// Round-robin replacement pointer with clear and step.
module asn_tlb_rr #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (clr) begin
      ptr_d = '0;
    end else if (step) begin
      ptr_d = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (clr || step) ptr <= ptr_d;
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 43,
  parameter int PPN_W   = 27,
  parameter int ASN_W   = 8,
  localparam int VPN_W  = VA_W - PAGE_SHIFT,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_global,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_fault_rd,
  output logic             lk_fault_wr,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_vaddr,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_fault_rd,
  input  logic             ins_fault_wr,
  input  logic             flush_all,
  input  logic             flush_proc,
  input  logic             flush_page,
  input  logic [VA_W-1:0]  flush_vaddr,
  input  logic [ASN_W-1:0] flush_asn,
  input  logic             rp_adv,
  output logic [IDX_W-1:0] rp_ptr,
  output logic             rp_valid,
  output logic [VPN_W-1:0] rp_vpn,
  output logic [PPN_W-1:0] rp_ppn,
  output logic [ASN_W-1:0] rp_asn,
  output logic             rp_global
);
  // Slot state: valid flags are reset; payload fields are write-enabled only.
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] glob_q, frd_q, fwr_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q [ENTRIES];
  logic [MODES-1:0]   rd_q  [ENTRIES];
  logic [MODES-1:0]   wr_q  [ENTRIES];

  logic               ins_we;
  logic [ENTRIES-1:0] lk_match, pg_match;
  logic               lk_any;

  assign ins_we = ins_en && !flush_all;

  asn_tlb_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (flush_all),
    .step (ins_en || rp_adv),
    .ptr  (rp_ptr)
  );

  asn_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_cmp (
    .valid  (valid_q),
    .glob   (glob_q),
    .tag    (tag_q),
    .asn    (asn_q),
    .req_vpn(lk_vaddr[VA_W-1:PAGE_SHIFT]),
    .req_asn(lk_asn),
    .match  (lk_match)
  );

  asn_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_pg_cmp (
    .valid  (valid_q),
    .glob   (glob_q),
    .tag    (tag_q),
    .asn    (asn_q),
    .req_vpn(flush_vaddr[VA_W-1:PAGE_SHIFT]),
    .req_asn(flush_asn),
    .match  (pg_match)
  );

  asn_tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_pri (
    .vec(lk_match),
    .any(lk_any),
    .idx(lk_idx)
  );

  // Lookup result, zeroed on a miss.
  always_comb begin
    lk_hit      = lk_any;
    lk_ppn      = '0;
    lk_global   = 1'b0;
    lk_rd_en    = '0;
    lk_wr_en    = '0;
    lk_fault_rd = 1'b0;
    lk_fault_wr = 1'b0;
    if (lk_any) begin
      lk_ppn      = ppn_q[lk_idx];
      lk_global   = glob_q[lk_idx];
      lk_rd_en    = rd_q[lk_idx];
      lk_wr_en    = wr_q[lk_idx];
      lk_fault_rd = frd_q[lk_idx];
      lk_fault_wr = fwr_q[lk_idx];
    end
  end

  // Readback of the slot under the replacement pointer.
  assign rp_valid  = valid_q[rp_ptr];
  assign rp_vpn    = tag_q[rp_ptr];
  assign rp_ppn    = ppn_q[rp_ptr];
  assign rp_asn    = asn_q[rp_ptr];
  assign rp_global = glob_q[rp_ptr];

  // Valid next state: flushes act on old contents, insert lands afterwards.
  always_comb begin
    valid_d = valid_q;
    if (flush_all) begin
      valid_d = '0;
    end else begin
      if (flush_proc) valid_d = valid_d & glob_q;
      if (flush_page) valid_d = valid_d & ~pg_match;
      if (ins_we)     valid_d[rp_ptr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic wr_sel;
    assign wr_sel = ins_we && (rp_ptr == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (wr_sel) begin
        tag_q[i]  <= ins_vaddr[VA_W-1:PAGE_SHIFT];
        ppn_q[i]  <= ins_ppn;
        asn_q[i]  <= ins_asn;
        glob_q[i] <= ins_global;
        rd_q[i]   <= ins_rd_en;
        wr_q[i]   <= ins_wr_en;
        frd_q[i]  <= ins_fault_rd;
        fwr_q[i]  <= ins_fault_wr;
      end
    end
  end
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_all,
  input logic             ins_en,
  input logic             rp_adv,
  input logic [IDX_W-1:0] rp_ptr,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  AST_FLUSH_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (rp_ptr == '0)); // R3

  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_all && (ins_en || rp_adv)) |=>
      (rp_ptr == (($past(rp_ptr) == LAST) ? '0 : IDX_W'($past(rp_ptr) + 1'b1)))); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_all && !ins_en && !rp_adv) |=> $stable(rp_ptr)); // R7

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rp_ptr <= LAST); // R6

  AST_HIT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_idx <= LAST)); // R2
endmodule

bind asn_tlb asn_tlb_chk #(.N(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush_all(flush_all),
  .ins_en   (ins_en),
  .rp_adv   (rp_adv),
  .rp_ptr   (rp_ptr),
  .lk_hit   (lk_hit),
  .lk_idx   (lk_idx)
);

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  localparam int N = 4, VA_W = 43, PPN_W = 27, ASN_W = 8, IDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [VA_W-1:0] lk_vaddr = '0, ins_vaddr = '0, flush_vaddr = '0;
  logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, flush_asn = '0;
  logic [PPN_W-1:0] ins_ppn = '0, lk_ppn, rp_ppn;
  logic [3:0] ins_rd_en = '0, ins_wr_en = '0, lk_rd_en, lk_wr_en;
  logic ins_en = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
  logic flush_all = 0, flush_proc = 0, flush_page = 0, rp_adv = 0;
  logic lk_hit, lk_global, lk_fault_rd, lk_fault_wr, rp_valid, rp_global;
  logic [IDX_W-1:0] lk_idx, rp_ptr;
  logic [VA_W-14:0] rp_vpn;
  logic [ASN_W-1:0] rp_asn;

  asn_tlb #(.ENTRIES(N), .VA_W(VA_W), .PPN_W(PPN_W), .ASN_W(ASN_W)) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] va(input longint vpn, input longint off);
    return VA_W'((vpn << 13) | off);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    ins_en = 0; flush_all = 0; flush_proc = 0; flush_page = 0; rp_adv = 0;
  endtask

  task automatic set_ins(input longint vpn, input longint ppn, input int asn,
                         input bit g, input logic [3:0] rd, input logic [3:0] wr,
                         input bit frd, input bit fwr);
    ins_en = 1; ins_vaddr = va(vpn, 'h1a4); ins_ppn = PPN_W'(ppn);
    ins_asn = ASN_W'(asn); ins_global = g; ins_rd_en = rd; ins_wr_en = wr;
    ins_fault_rd = frd; ins_fault_wr = fwr;
  endtask

  task automatic look(input longint vpn, input int asn);
    lk_vaddr = va(vpn, 'h44); lk_asn = ASN_W'(asn); #1;
  endtask

  task automatic t_reset();
    look('h100, 5);
    chk(lk_hit == 0, "R9 hit", lk_hit, 0);
    chk(rp_ptr == 0, "R9 ptr", rp_ptr, 0);
    chk(rp_valid == 0, "R9 valid", rp_valid, 0);
  endtask

  task automatic t_insert_lookup();
    set_ins('h100, 'h1234, 5, 0, 4'b0011, 4'b0001, 1, 0); tick();
    look('h100, 5);
    chk(lk_hit && lk_idx == 0, "R1 asn hit", lk_idx, 0);
    chk(lk_ppn == 'h1234 && lk_rd_en == 4'b0011 && lk_wr_en == 4'b0001 &&
        lk_fault_rd && !lk_fault_wr && !lk_global, "R10 fields", lk_ppn, 'h1234);
    look('h100, 6);
    chk(!lk_hit && lk_ppn == 0 && lk_rd_en == 0, "R1/R10 asn miss", lk_hit, 0);
    set_ins('h200, 'h55, 1, 1, 4'b1111, 4'b1100, 0, 1); tick();
    look('h200, 9);
    chk(lk_hit && lk_idx == 1 && lk_global && lk_fault_wr, "R1 global hit", lk_idx, 1);
    chk(rp_ptr == 2, "R6 ptr advance", rp_ptr, 2);
  endtask

  task automatic t_priority();
    set_ins('h300, 'h0aa, 3, 0, 4'b0001, 4'b0001, 0, 0); tick();
    set_ins('h300, 'h0bb, 0, 1, 4'b0001, 4'b0001, 0, 0); tick();
    chk(rp_ptr == 0, "R6 wrap", rp_ptr, 0);
    look('h300, 3);
    chk(lk_hit && lk_idx == 2 && lk_ppn == 'h0aa, "R2 lowest index", lk_idx, 2);
    look('h300, 4);
    chk(lk_hit && lk_idx == 3 && lk_ppn == 'h0bb, "R2 global only", lk_idx, 3);
  endtask

  task automatic t_readback();
    chk(rp_valid && rp_vpn == 'h100 && rp_asn == 5 && rp_ppn == 'h1234, "R7 readback", rp_vpn, 'h100);
    rp_adv = 1; tick();
    chk(rp_ptr == 1 && rp_vpn == 'h200 && rp_global, "R7 adv", rp_ptr, 1);
    set_ins('h400, 'h77, 7, 0, 4'b0001, 4'b0001, 0, 0); rp_adv = 1; tick();
    chk(rp_ptr == 2, "R7 ins+adv once", rp_ptr, 2);
    look('h200, 9);
    chk(!lk_hit, "R6 overwrite old", lk_hit, 0);
    look('h400, 7);
    chk(lk_hit && lk_idx == 1, "R6 overwrite new", lk_idx, 1);
  endtask

  task automatic t_same_cycle();
    set_ins('h500, 'h99, 1, 0, 4'b0001, 4'b0001, 0, 0);
    look('h500, 1);
    chk(!lk_hit, "R8 pre-insert view", lk_hit, 0);
    tick(); #1;
    chk(lk_hit && lk_idx == 2, "R8 post-insert", lk_idx, 2);
    look('h300, 3);
    chk(lk_hit && lk_idx == 3, "R6 slot2 replaced", lk_idx, 3);
  endtask

  task automatic t_flush_page();
    flush_page = 1; flush_vaddr = va('h300, 0); flush_asn = 99; tick();
    look('h300, 3);
    chk(!lk_hit, "R5 global page", lk_hit, 0);
    flush_page = 1; flush_vaddr = va('h100, 0); flush_asn = 6; tick();
    look('h100, 5);
    chk(lk_hit && lk_idx == 0, "R5 other asn kept", lk_idx, 0);
    look('h400, 7);
    chk(lk_hit, "R5 other page kept", lk_hit, 1);
    flush_page = 1; flush_vaddr = va('h100, 0); flush_asn = 5; tick();
    look('h100, 5);
    chk(!lk_hit, "R5 asn match", lk_hit, 0);
  endtask

  task automatic t_flush_proc();
    set_ins('h600, 'h66, 2, 1, 4'b0001, 4'b0001, 0, 0); tick();
    chk(rp_ptr == 0, "R6 wrap2", rp_ptr, 0);
    set_ins('h700, 'h70, 2, 0, 4'b0001, 4'b0001, 0, 0); flush_proc = 1; tick();
    look('h400, 7);
    chk(!lk_hit, "R4 private gone", lk_hit, 0);
    look('h500, 1);
    chk(!lk_hit, "R4 private gone 2", lk_hit, 0);
    look('h600, 8);
    chk(lk_hit && lk_idx == 3, "R4 global kept", lk_idx, 3);
    look('h700, 2);
    chk(lk_hit && lk_idx == 0, "R8 insert survives flush", lk_idx, 0);
  endtask

  task automatic t_flush_all();
    chk(rp_ptr == 1, "R6 ptr before flush", rp_ptr, 1);
    set_ins('h800, 'h80, 1, 1, 4'b0001, 4'b0001, 0, 0); flush_all = 1; tick();
    chk(rp_ptr == 0 && !rp_valid, "R3 ptr zero", rp_ptr, 0);
    look('h600, 8);
    chk(!lk_hit, "R3 global cleared", lk_hit, 0);
    look('h700, 2);
    chk(!lk_hit, "R3 private cleared", lk_hit, 0);
    look('h800, 1);
    chk(!lk_hit, "R3 insert dropped", lk_hit, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_insert_lookup();
    t_priority();
    t_readback();
    t_same_cycle();
    t_flush_page();
    t_flush_proc();
    t_flush_all();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end
endmodule